// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

The block is a bus-attached watchdog. A down-counter steps once per bus clock, or once per pulse of a 1 MHz tick enable when the control register selects that rate. Software stores a reload value. It arms the counter by writing a fixed 16-bit key to a restart location. It then sets the enable bit. Any other value written to the restart location is discarded, so a stray write cannot keep a failed system alive.

When the counter takes a step while it is at zero, the block raises an expiry event and reloads itself. In the cycle that follows, each expiry output selected in the control register pulses high for one cycle: a reset request, an interrupt, and an external trigger. A reset-scope code is decoded from the control register and presented continuously. A status register keeps a sticky timeout flag. It also keeps a sticky flag that marks an expiry which requested a reset with secondary boot selected. That second flag is also driven out as a level.

Bus reads are combinational from the address; writes take effect at the clock edge that samples them.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the count and reload registers both hold the parameter RESET_LOAD. The control register and status register read 0, and every output is low.
- R2: Writing exactly 0x0000_4755 to offset 0x08 copies the reload register (offset 0x04) into the count at that clock edge.
- R3: Any other value written to offset 0x08 is ignored, and the count is left unchanged.
- R4: While control bit 0 (enable) is clear, the count is frozen. Offset 0x00 always reads the live count.
- R5: With control bit 4 clear, an enabled counter steps down by one on every clock. With bit 4 set, it steps only on clocks where tick_1mhz is high.
- R6: A step taken while the count is 0 is an expiry. The count reloads from the reload register, so the timeout lasts reload+1 steps.
- R7: In the clock after an expiry, each selected output pulses high for exactly one cycle. rst_req follows control bit 1, irq follows bit 2 and ext_trig follows bit 3.
- R8: rst_scope decodes control bits 6:5. Field value 0 gives 0 (SoC), 1 gives 1 (full chip), and 2 or 3 give 2 (CPU only).
- R9: Status (offset 0x10) bit 0 is set by every expiry. Bit 1 is set by an expiry while control bits 1 and 7 are both set. alt_boot mirrors bit 1. Writing 1 to a status bit clears that bit.
- R10: The control register stores bits 7:0 and reads higher bits as 0. The reload register is fully readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1mhz | input | 1 | Slow step enable, used when control bit 4 is set |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_scope | output | 2 | Decoded reset scope |
| irq | output | 1 | One-cycle interrupt on expiry |
| ext_trig | output | 1 | One-cycle external trigger on expiry |
| alt_boot | output | 1 | Sticky secondary-boot flag |

## Verification
The bench times expiry across several reload and control settings. A design that expires at zero-entry instead of on the step taken from zero would be one cycle early. It also checks that each output follows only its own control bit and drops again after one cycle; a level-held or crossed output would show up there. Near-miss keys, including the right key with upper bits set, must leave the count alone, and a decoder that compares only 16 bits would fail that check. Scope field 3 must map to CPU, the counter must ignore clocks without a tick in slow mode, and clearing one status bit must keep the other.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 5;
  localparam int CTL_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_COUNT   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_RELOAD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_RESTART = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CTL     = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 5'h10;

  localparam int CB_EN    = 0;
  localparam int CB_RST   = 1;
  localparam int CB_IRQ   = 2;
  localparam int CB_EXT   = 3;
  localparam int CB_SLOW  = 4;
  localparam int CB_SCOPE = 5;
  localparam int CB_BOOT  = 7;

  typedef enum logic [1:0] {
    SCOPE_SOC  = 2'd0,
    SCOPE_FULL = 2'd1,
    SCOPE_CPU  = 2'd2
  } scope_e;

  function automatic scope_e decode_scope(input logic [1:0] field);
    case (field)
      2'd0:    return SCOPE_SOC;
      2'd1:    return SCOPE_FULL;
      default: return SCOPE_CPU;
    endcase
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] RESET_LOAD = '0,
  parameter logic [15:0]       KEY        = 16'h4755
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count_i,
  input  logic [1:0]        sts_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              restart_o,
  output logic [1:0]        sts_clr_o,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] KEY_FULL = {{(DATA_W-16){1'b0}}, KEY};

  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic [DATA_W-1:0] reload_q, reload_d;
  logic              wr_ctl, wr_reload;

  always_comb begin
    wr_ctl    = wr_en && (addr == OFF_CTL);
    wr_reload = wr_en && (addr == OFF_RELOAD);
    restart_o = wr_en && (addr == OFF_RESTART) && (wdata == KEY_FULL);
    sts_clr_o = (wr_en && (addr == OFF_STATUS)) ? wdata[1:0] : 2'b00;
    ctl_d     = wr_ctl    ? wdata[CTL_W-1:0] : ctl_q;
    reload_d  = wr_reload ? wdata            : reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      reload_q <= RESET_LOAD;
    end else begin
      ctl_q    <= ctl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    case (addr)
      OFF_COUNT:  rdata = count_i;
      OFF_RELOAD: rdata = reload_q;
      OFF_CTL:    rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
      OFF_STATUS: rdata = {{(DATA_W-2){1'b0}}, sts_i};
      default:    rdata = '0;
    endcase
  end

  assign ctl_o    = ctl_q;
  assign reload_o = reload_q;

  p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_o));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] RESET_LOAD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              use_tick,
  input  logic              tick,
  input  logic              restart,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] count_q, count_d;
  logic              step;

  always_comb begin
    step     = en && (use_tick ? tick : 1'b1);
    expire_o = step && (count_q == '0) && !restart;
    if (restart || expire_o)
      count_d = reload;
    else if (step)
      count_d = count_q - 1'b1;
    else
      count_d = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= RESET_LOAD;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> $stable(count_o));
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_o == $past(reload)));
  p_onestep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && count_o != '0) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (count_o == $past(reload)));
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic [CTL_W-1:0] ctl,
  input  logic [1:0]       sts_clr,
  output logic             rst_req_o,
  output logic             irq_o,
  output logic             ext_o,
  output logic [1:0]       sts_o
);
  logic       rst_d, irq_d, ext_d;
  logic [1:0] sts_q, sts_d;

  always_comb begin
    rst_d    = expire && ctl[CB_RST];
    irq_d    = expire && ctl[CB_IRQ];
    ext_d    = expire && ctl[CB_EXT];
    sts_d[0] = expire || (sts_q[0] && !sts_clr[0]);
    sts_d[1] = (expire && ctl[CB_RST] && ctl[CB_BOOT]) || (sts_q[1] && !sts_clr[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_o <= 1'b0;
      irq_o     <= 1'b0;
      ext_o     <= 1'b0;
      sts_q     <= 2'b00;
    end else begin
      rst_req_o <= rst_d;
      irq_o     <= irq_d;
      ext_o     <= ext_d;
      sts_q     <= sts_d;
    end
  end

  assign sts_o = sts_q;

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !expire) |=> !rst_req_o);
  p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sts_o[0]);
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(expire));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] RESET_LOAD = 32'd30_000_000,
  parameter logic [15:0]       KEY        = 16'h4755
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1mhz,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic [1:0]        rst_scope,
  output logic              irq,
  output logic              ext_trig,
  output logic              alt_boot
);
  logic              rst_meta, rst_sync;
  logic [CTL_W-1:0]  ctl;
  logic [DATA_W-1:0] reload, count;
  logic              restart, expire;
  logic [1:0]        sts, sts_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  wdt_regs #(.DATA_W(DATA_W), .RESET_LOAD(RESET_LOAD), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .count_i(count), .sts_i(sts), .ctl_o(ctl),
    .reload_o(reload), .restart_o(restart), .sts_clr_o(sts_clr),
    .rdata(bus_rdata));

  wdt_counter #(.DATA_W(DATA_W), .RESET_LOAD(RESET_LOAD)) u_cnt (
    .clk(clk), .rst_n(rst_sync), .en(ctl[CB_EN]), .use_tick(ctl[CB_SLOW]),
    .tick(tick_1mhz), .restart(restart), .reload(reload),
    .count_o(count), .expire_o(expire));

  wdt_expiry u_exp (
    .clk(clk), .rst_n(rst_sync), .expire(expire), .ctl(ctl),
    .sts_clr(sts_clr), .rst_req_o(rst_req), .irq_o(irq), .ext_o(ext_trig),
    .sts_o(sts));

  assign rst_scope = decode_scope(ctl[CB_SCOPE+1:CB_SCOPE]);
  assign alt_boot  = sts[1];

  p_scope_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    rst_scope != 2'd3);
  p_altboot_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(alt_boot) |-> $past(expire));
endmodule

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
  import wdt_pkg::*;

  localparam logic [31:0] RL = 32'd30_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, irq, ext_trig, alt_boot;
  logic [1:0]  scope;
  int          tests = 0, fails = 0;

  always #10 clk = ~clk;

  wdt_keyed u0 (
    .clk(clk), .rst_n(rst_n), .tick_1mhz(tick), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .rst_req(rst_req), .rst_scope(scope),
    .irq(irq), .ext_trig(ext_trig), .alt_boot(alt_boot));

  // {reload, control without enable}
  localparam logic [39:0] VEC [4] = '{
    {32'd3,  8'h02},
    {32'd7,  8'h24},
    {32'd12, 8'hCA},
    {32'd1,  8'h6E}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run_vec(input logic [31:0] rl, input logic [7:0] c);
    logic [31:0] d;
    int n;
    logic [1:0] es;
    wr_reg(OFF_CTL, 32'h0);
    wr_reg(OFF_STATUS, 32'h3);
    wr_reg(OFF_RELOAD, rl);
    wr_reg(OFF_RESTART, 32'h4755);
    wr_reg(OFF_CTL, {24'h0, c | 8'h01});
    addr = OFF_COUNT;
    n = 0;
    while (n < 200) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (rst_req || irq || ext_trig) break;
    end
    check(n == int'(rl) + 1, "R6 expiry step count", n, rl + 1);
    #1;
    check(rdata == rl, "R6 count reloaded", rdata, rl);
    check(rst_req == c[1] && irq == c[2] && ext_trig == c[3], "R7 selected outputs",
          {rst_req, irq, ext_trig}, {c[1], c[2], c[3]});
    es = (c[6:5] >= 2'd2) ? 2'd2 : c[6:5];
    check(scope == es, "R8 scope decode", scope, es);
    @(negedge clk);
    check(!rst_req && !irq && !ext_trig, "R7 one-cycle pulse", {rst_req, irq, ext_trig}, 0);
    rd_reg(OFF_STATUS, d);
    check(d[1:0] == {c[1] & c[7], 1'b1}, "R9 status capture", d, {c[1] & c[7], 1'b1});
    check(alt_boot == (c[1] & c[7]), "R9 alt_boot", alt_boot, c[1] & c[7]);
    wr_reg(OFF_CTL, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_reg(OFF_COUNT, d);  check(d == RL, "R1 count", d, RL);
    rd_reg(OFF_RELOAD, d); check(d == RL, "R1 reload", d, RL);
    rd_reg(OFF_CTL, d);    check(d == 0, "R1 ctl", d, 0);
    rd_reg(OFF_STATUS, d); check(d == 0, "R1 status", d, 0);
    check({rst_req, irq, ext_trig, alt_boot} == 0, "R1 outputs", {rst_req, irq, ext_trig, alt_boot}, 0);

    // R10 control width
    wr_reg(OFF_CTL, 32'hFFFF_FF10);
    rd_reg(OFF_CTL, d); check(d == 32'h10, "R10 ctl readback", d, 32'h10);
    wr_reg(OFF_CTL, 32'h0);
    wr_reg(OFF_RELOAD, 32'hDEAD_BEEF);
    rd_reg(OFF_RELOAD, d); check(d == 32'hDEAD_BEEF, "R10 reload readback", d, 32'hDEAD_BEEF);

    // R2 keyed restart
    wr_reg(OFF_RELOAD, 32'd100);
    wr_reg(OFF_RESTART, 32'h4755);
    rd_reg(OFF_COUNT, d); check(d == 100, "R2 restart loads", d, 100);

    // R3 wrong keys ignored
    wr_reg(OFF_RELOAD, 32'd50);
    wr_reg(OFF_RESTART, 32'h4756);
    rd_reg(OFF_COUNT, d); check(d == 100, "R3 near key", d, 100);
    wr_reg(OFF_RESTART, 32'h0001_4755);
    rd_reg(OFF_COUNT, d); check(d == 100, "R3 upper bits set", d, 100);

    // R4 frozen while disabled
    repeat (5) @(negedge clk);
    rd_reg(OFF_COUNT, d); check(d == 100, "R4 frozen", d, 100);

    // R5 tick mode
    wr_reg(OFF_CTL, 32'h11);
    repeat (5) @(negedge clk);
    rd_reg(OFF_COUNT, d); check(d == 100, "R5 no tick no step", d, 100);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    rd_reg(OFF_COUNT, d); check(d == 99, "R5 one tick", d, 99);
    wr_reg(OFF_CTL, 32'h01);
    rd_reg(OFF_COUNT, d); check(d == 99, "R5 mode switch edge", d, 99);
    repeat (3) @(negedge clk);
    rd_reg(OFF_COUNT, d); check(d == 96, "R5 every clock", d, 96);
    wr_reg(OFF_CTL, 32'h0);

    // R6 R7 R8 R9 vector table
    for (int i = 0; i < 4; i++) run_vec(VEC[i][39:8], VEC[i][7:0]);

    // R9 write-1-to-clear per bit
    run_vec(32'd5, 8'h82);
    wr_reg(OFF_STATUS, 32'h1);
    rd_reg(OFF_STATUS, d); check(d == 32'h2, "R9 clear bit0 only", d, 32'h2);
    check(alt_boot == 1'b1, "R9 alt_boot kept", alt_boot, 1);
    wr_reg(OFF_STATUS, 32'h2);
    rd_reg(OFF_STATUS, d); check(d == 0, "R9 clear bit1", d, 0);
    check(alt_boot == 1'b0, "R9 alt_boot cleared", alt_boot, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule